// File: doc/BRIEF.md
# Received Packet Filter and Status Appender

This block sits behind the byte synchroniser of a packet receiver. Once a start-of-packet pulse marks the first byte after the sync word, it takes de-whitened bytes one at a time. It works out how long the packet is, filters the packet by length and by destination address, and verifies a 16-bit CRC. Bytes it accepts go out through a single-byte write port into the receive FIFO. Optionally, two status bytes holding signal strength, link quality and the CRC verdict are appended after the data.

A packet that fails the length or address filter stops being written at the byte that failed. The block then pulses a restart request so that the receiver goes back to hunting for a sync word. A CRC failure can instead pulse a flush request that empties the whole FIFO. Three length modes are supported:
- fixed, where the count comes from a configured register;
- variable, where the first byte carries the count;
- unbounded, which runs until the next start pulse.

Configuration inputs must stay constant while a packet is in progress. Input bytes arrive at most every other clock cycle.

Top module: `rx_pkt_filter`

## Requirements
- R1: With `cfg_len_mode`=0 (fixed), exactly `cfg_pkt_len` bytes after the start pulse are written to the FIFO. Further bytes are not written until the next start pulse. A `cfg_pkt_len` of 0 ends the data phase at once.
- R2: With `cfg_len_mode`=1 (variable), the first byte is the length. It is written to the FIFO, and then exactly that many further bytes are written. A length of 0 goes straight to the CRC phase.
- R3: In variable mode, a length byte strictly greater than `cfg_pkt_len` is not written. `rx_restart` pulses for one cycle, in the cycle after that byte is sampled, and later bytes of the packet are not written.
- R4: The address filter applies to the first byte after the length byte (fixed/variable) or to the first byte (unbounded). `cfg_addr_mode` selects the rule: 0 = no filtering; 1 = equal to `cfg_node_addr` only; 2 = node address or 0x00; 3 = node address, 0x00 or 0xFF.
- R5: An address byte that fails the filter is not written. `rx_restart` pulses one cycle after it, and the rest of the packet is dropped. Bytes written before it stay written.
- R6: When `cfg_crc_en`=1, two CRC bytes follow the data and are not written to the FIFO. The CRC uses polynomial 0x8005, MSB first, with a 0xFFFF start value, over the length, address and payload bytes. It passes when the remainder over data plus the received CRC is 0.
- R7: When `cfg_append_en`=1, the packet end writes the RSSI byte and then {crc_ok, lqi[6:0]} in the two cycles that follow. crc_ok is 1 if the CRC passed or CRC is disabled.
- R8: When `cfg_crc_en`=1, `cfg_autoflush_en`=1 and the CRC fails, `fifo_flush` pulses one cycle after the last CRC byte, and no status bytes are written.
- R9: With `cfg_len_mode`=2 or 3 (unbounded), no CRC or status is used. If address filtering is on, a matching first byte is written as 0xFF, then the address byte in the following cycle, then every later byte. With filtering off, every byte is written.
- R10: A start pulse abandons any packet in progress. It produces no write, flush or restart in the following cycle.
- R11: During and after reset, `fifo_we`, `fifo_flush` and `rx_restart` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len_mode | input | 2 | 0 fixed, 1 variable, 2/3 unbounded |
| cfg_pkt_len | input | 8 | Fixed length, or maximum length in variable mode |
| cfg_addr_mode | input | 2 | Address filter rule (0..3) |
| cfg_node_addr | input | 8 | Own node address |
| cfg_crc_en | input | 1 | CRC phase present and checked |
| cfg_append_en | input | 1 | Append two status bytes |
| cfg_autoflush_en | input | 1 | Flush FIFO on CRC failure |
| sync_found | input | 1 | Start-of-packet pulse |
| rx_valid | input | 1 | Input byte valid |
| rx_byte | input | 8 | De-whitened received byte |
| rssi_in | input | 8 | Signal strength for status byte 1 |
| lqi_in | input | 7 | Link quality for status byte 2 |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write data |
| fifo_flush | output | 1 | Flush the whole FIFO |
| rx_restart | output | 1 | Discard packet and resume sync search |

## Verification
Each accepted byte reaches `fifo_we`/`fifo_wdata` one cycle after the edge that samples it. In unbounded mode the pending address follows one cycle later still. The two status bytes occupy the first and second cycles after the edge that takes the final data or CRC byte. Flush and restart pulses appear one cycle after the deciding byte. The bench drives inputs and records outputs on the falling edge, so every registered result is seen half a cycle after it is produced. It waits several idle cycles after each packet before comparing the recorded write sequence and pulse counts with a bench model.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned CRC_W    = 16;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h8005;
    localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;
    localparam logic [BYTE_W-1:0] INF_MARK = 8'hFF;

    typedef enum logic [1:0] {
        LEN_FIXED = 2'd0,
        LEN_VAR   = 2'd1,
        LEN_INF   = 2'd2,
        LEN_INF2  = 2'd3
    } len_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LEN,
        ST_DATA,
        ST_CRC_HI,
        ST_CRC_LO,
        ST_APP_RSSI,
        ST_APP_LQI,
        ST_INF_ADDR,
        ST_INF_PEND,
        ST_INF_DATA
    } state_e;

    typedef struct packed {
        logic              we;
        logic [BYTE_W-1:0] data;
    } wr_t;

    typedef struct packed {
        logic restart;
        logic flush;
    } evt_t;

    // One byte of a left-shifting CRC, most significant bit first.
    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0]  c,
        input logic [BYTE_W-1:0] d
    );
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ d[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/rxf_crc16.sv
`timescale 1ns/1ps
module rxf_crc16 import rxf_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              step,
    input  logic [BYTE_W-1:0] din,
    output logic [CRC_W-1:0]  crc_nxt
);
    logic [CRC_W-1:0] crc_q;

    assign crc_nxt = crc_step_byte(crc_q, din);

    always_ff @(posedge clk) begin
        if (rst || clr) crc_q <= CRC_SEED;
        else if (step)  crc_q <= crc_nxt;
    end
endmodule

// File: rtl/rxf_byte_ctr.sv
`timescale 1ns/1ps
module rxf_byte_ctr #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);
    logic [W-1:0] remain_q;

    assign last = (remain_q == W'(1));

    always_ff @(posedge clk) begin
        if (rst)       remain_q <= '0;
        else if (load) remain_q <= load_val;
        else if (dec)  remain_q <= remain_q - W'(1);
    end
endmodule

// File: rtl/rxf_addr_match.sv
`timescale 1ns/1ps
module rxf_addr_match #(
    parameter int unsigned W      = 8,
    parameter int unsigned N_BC   = 2,
    parameter logic [N_BC*W-1:0] BC_LIST = {8'hFF, 8'h00}
) (
    input  logic [1:0]   mode,
    input  logic [W-1:0] node,
    input  logic [W-1:0] candidate,
    output logic         hit
);
    // Broadcast entry k is honoured when mode exceeds k+1.
    logic [N_BC-1:0] bc_hit;

    for (genvar k = 0; k < N_BC; k++) begin : g_bc
        assign bc_hit[k] = (int'(mode) > k + 1) &&
                           (candidate == BC_LIST[k*W +: W]);
    end

    assign hit = (mode == 2'd0) || (candidate == node) || (|bc_hit);
endmodule

// File: rtl/rx_pkt_filter.sv
`timescale 1ns/1ps
module rx_pkt_filter import rxf_pkg::*; #(
    parameter int unsigned CNT_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_len_mode,
    input  logic [7:0]        cfg_pkt_len,
    input  logic [1:0]        cfg_addr_mode,
    input  logic [7:0]        cfg_node_addr,
    input  logic              cfg_crc_en,
    input  logic              cfg_append_en,
    input  logic              cfg_autoflush_en,
    input  logic              sync_found,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic [7:0]        rssi_in,
    input  logic [6:0]        lqi_in,
    output logic              fifo_we,
    output logic [7:0]        fifo_wdata,
    output logic              fifo_flush,
    output logic              rx_restart
);
    localparam int unsigned LQI_W = BYTE_W - 1;

    state_e            st_q, st_n;
    wr_t               wr_q, wr_n;
    evt_t              ev_q, ev_n;
    logic              first_q, first_n;
    logic              ok_q, ok_n;
    logic [BYTE_W-1:0] pend_q, pend_n;

    logic              crc_clr, crc_step;
    logic [CRC_W-1:0]  crc_nxt;
    logic              ctr_load, ctr_dec, ctr_last;
    logic [CNT_W-1:0]  ctr_val;
    logic              addr_hit;
    len_mode_e         lmode;
    state_e            end_st;
    logic              filt_on;

    assign lmode   = len_mode_e'(cfg_len_mode);
    assign filt_on = (cfg_addr_mode != 2'd0);
    assign end_st  = cfg_crc_en    ? ST_CRC_HI  :
                     cfg_append_en ? ST_APP_RSSI : ST_IDLE;

    rxf_crc16 i_crc (
        .clk     (clk),
        .rst     (rst),
        .clr     (crc_clr),
        .step    (crc_step),
        .din     (rx_byte),
        .crc_nxt (crc_nxt)
    );

    rxf_byte_ctr #(.W(CNT_W)) i_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (ctr_load),
        .load_val (ctr_val),
        .dec      (ctr_dec),
        .last     (ctr_last)
    );

    rxf_addr_match #(.W(BYTE_W)) i_addr (
        .mode      (cfg_addr_mode),
        .node      (cfg_node_addr),
        .candidate (rx_byte),
        .hit       (addr_hit)
    );

    always_comb begin
        st_n     = st_q;
        wr_n     = '0;
        ev_n     = '0;
        first_n  = first_q;
        ok_n     = ok_q;
        pend_n   = pend_q;
        crc_clr  = 1'b0;
        crc_step = 1'b0;
        ctr_load = 1'b0;
        ctr_dec  = 1'b0;
        ctr_val  = CNT_W'(cfg_pkt_len);

        if (sync_found) begin
            crc_clr = 1'b1;
            ok_n    = 1'b1;
            first_n = 1'b1;
            unique case (lmode)
                LEN_FIXED: begin
                    if (cfg_pkt_len == '0) begin
                        st_n = end_st;
                    end else begin
                        ctr_load = 1'b1;
                        st_n     = ST_DATA;
                    end
                end
                LEN_VAR: st_n = ST_LEN;
                default: st_n = filt_on ? ST_INF_ADDR : ST_INF_DATA;
            endcase
        end else begin
            unique case (st_q)
                ST_LEN: if (rx_valid) begin
                    if (rx_byte > cfg_pkt_len) begin
                        ev_n.restart = 1'b1;
                        st_n         = ST_IDLE;
                    end else begin
                        wr_n     = '{we: 1'b1, data: rx_byte};
                        crc_step = 1'b1;
                        if (rx_byte == '0) begin
                            st_n = end_st;
                        end else begin
                            ctr_load = 1'b1;
                            ctr_val  = CNT_W'(rx_byte);
                            st_n     = ST_DATA;
                        end
                    end
                end
                ST_DATA: if (rx_valid) begin
                    if (first_q && !addr_hit) begin
                        ev_n.restart = 1'b1;
                        st_n         = ST_IDLE;
                    end else begin
                        wr_n     = '{we: 1'b1, data: rx_byte};
                        crc_step = 1'b1;
                        ctr_dec  = 1'b1;
                        first_n  = 1'b0;
                        if (ctr_last) st_n = end_st;
                    end
                end
                ST_CRC_HI: if (rx_valid) begin
                    crc_step = 1'b1;
                    st_n     = ST_CRC_LO;
                end
                ST_CRC_LO: if (rx_valid) begin
                    crc_step = 1'b1;
                    ok_n     = (crc_nxt == '0);
                    if ((crc_nxt != '0) && cfg_autoflush_en) begin
                        ev_n.flush = 1'b1;
                        st_n       = ST_IDLE;
                    end else begin
                        st_n = cfg_append_en ? ST_APP_RSSI : ST_IDLE;
                    end
                end
                ST_APP_RSSI: begin
                    wr_n = '{we: 1'b1, data: rssi_in};
                    st_n = ST_APP_LQI;
                end
                ST_APP_LQI: begin
                    wr_n = '{we: 1'b1, data: {ok_q, lqi_in[LQI_W-1:0]}};
                    st_n = ST_IDLE;
                end
                ST_INF_ADDR: if (rx_valid) begin
                    if (addr_hit) begin
                        wr_n   = '{we: 1'b1, data: INF_MARK};
                        pend_n = rx_byte;
                        st_n   = ST_INF_PEND;
                    end else begin
                        ev_n.restart = 1'b1;
                        st_n         = ST_IDLE;
                    end
                end
                ST_INF_PEND: begin
                    wr_n = '{we: 1'b1, data: pend_q};
                    st_n = ST_INF_DATA;
                end
                ST_INF_DATA: if (rx_valid) begin
                    wr_n = '{we: 1'b1, data: rx_byte};
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            wr_q    <= '0;
            ev_q    <= '0;
            first_q <= 1'b0;
            ok_q    <= 1'b1;
            pend_q  <= '0;
        end else begin
            st_q    <= st_n;
            wr_q    <= wr_n;
            ev_q    <= ev_n;
            first_q <= first_n;
            ok_q    <= ok_n;
            pend_q  <= pend_n;
        end
    end

    assign fifo_we    = wr_q.we;
    assign fifo_wdata = wr_q.data;
    assign fifo_flush = ev_q.flush;
    assign rx_restart = ev_q.restart;
endmodule

// File: rtl/rxf_checker.sv
`timescale 1ns/1ps
module rxf_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cfg_len_mode,
    input logic [1:0] cfg_addr_mode,
    input logic       cfg_crc_en,
    input logic       cfg_autoflush_en,
    input logic       sync_found,
    input logic       rx_valid,
    input logic       fifo_we,
    input logic       fifo_flush,
    input logic       rx_restart
);
    // R11: outputs quiet while in reset
    always @(posedge clk) begin
        if (rst && $past(rst)) begin
            a_r11_reset_quiet: assert (!fifo_we && !fifo_flush && !rx_restart);
        end
    end

    // R5: a rejected byte is never written in the same cycle
    a_r5_reject_not_written: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fifo_we, fifo_flush, rx_restart}));

    // R3: restart only follows a sampled byte
    a_r3_restart_after_byte: assert property (@(posedge clk) disable iff (rst)
        rx_restart |-> ($past(rx_valid) && !$past(sync_found)));

    // R3 / R5: restart needs a length or address filter to be active
    a_r3_restart_cause: assert property (@(posedge clk) disable iff (rst)
        rx_restart |-> (($past(cfg_addr_mode) != 2'd0) || ($past(cfg_len_mode) == 2'd1)));

    // R8: flush only when CRC and auto-flush are both enabled
    a_r8_flush_enabled: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |-> ($past(cfg_crc_en) && $past(cfg_autoflush_en) && $past(rx_valid)));

    // R10: start pulse leaves the next cycle free of events
    a_r10_sync_silent: assert property (@(posedge clk) disable iff (rst)
        sync_found |=> (!fifo_we && !fifo_flush && !rx_restart));
endmodule

bind rx_pkt_filter rxf_checker i_rxf_checker (
    .clk              (clk),
    .rst              (rst),
    .cfg_len_mode     (cfg_len_mode),
    .cfg_addr_mode    (cfg_addr_mode),
    .cfg_crc_en       (cfg_crc_en),
    .cfg_autoflush_en (cfg_autoflush_en),
    .sync_found       (sync_found),
    .rx_valid         (rx_valid),
    .fifo_we          (fifo_we),
    .fifo_flush       (fifo_flush),
    .rx_restart       (rx_restart)
);

// File: tb/test_rx_pkt_filter.sv
`timescale 1ns/1ps
module test_rx_pkt_filter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_len_mode = '0;
    logic [7:0] cfg_pkt_len = '0;
    logic [1:0] cfg_addr_mode = '0;
    logic [7:0] cfg_node_addr = 8'h5A;
    logic       cfg_crc_en = 1'b0;
    logic       cfg_append_en = 1'b0;
    logic       cfg_autoflush_en = 1'b0;
    logic       sync_found = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [7:0] rssi_in = 8'hC3;
    logic [6:0] lqi_in = 7'h2D;
    logic       fifo_we;
    logic [7:0] fifo_wdata;
    logic       fifo_flush;
    logic       rx_restart;

    rx_pkt_filter i_rx_pkt_filter (.*);

    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;

    logic [7:0] pb [64];
    int         pn;
    logic [7:0] ex [80];
    int         en, ex_fl, ex_rs;
    logic [7:0] cap [80];
    int         cn = 0, cfl = 0, crs = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (fifo_we && cn < 80) begin cap[cn] = fifo_wdata; cn++; end
            if (fifo_flush) cfl++;
            if (rx_restart) crs++;
        end
    end

    function automatic logic [15:0] b_crc(input logic [15:0] c, input logic [7:0] d);
        logic fb;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ d[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h8005;
        end
        return c;
    endfunction

    function automatic bit b_match(input logic [7:0] a);
        if (cfg_addr_mode == 2'd0) return 1'b1;
        if (a == cfg_node_addr) return 1'b1;
        if (cfg_addr_mode >= 2'd2 && a == 8'h00) return 1'b1;
        if (cfg_addr_mode == 2'd3 && a == 8'hFF) return 1'b1;
        return 1'b0;
    endfunction

    task automatic push_ex(input logic [7:0] b);
        ex[en] = b; en++;
    endtask

    task automatic model();
        int i, n_data;
        logic [15:0] c;
        bit ok;
        en = 0; ex_fl = 0; ex_rs = 0; i = 0; c = 16'hFFFF;
        if (cfg_len_mode >= 2'd2) begin
            if (cfg_addr_mode != 2'd0 && pn > 0) begin
                if (!b_match(pb[0])) begin ex_rs = 1; return; end
                push_ex(8'hFF); push_ex(pb[0]); i = 1;
            end
            for (int k = i; k < pn; k++) push_ex(pb[k]);
            return;
        end
        if (cfg_len_mode == 2'd1) begin
            if (pn == 0) return;
            if (pb[0] > cfg_pkt_len) begin ex_rs = 1; return; end
            push_ex(pb[0]); c = b_crc(c, pb[0]); n_data = int'(pb[0]); i = 1;
        end else n_data = int'(cfg_pkt_len);
        for (int j = 0; j < n_data; j++) begin
            if (i >= pn) return;
            if (j == 0 && !b_match(pb[i])) begin ex_rs = 1; return; end
            push_ex(pb[i]); c = b_crc(c, pb[i]); i++;
        end
        ok = 1'b1;
        if (cfg_crc_en) begin
            if (i + 2 > pn) return;
            c = b_crc(c, pb[i]); c = b_crc(c, pb[i+1]);
            ok = (c == 16'h0);
            if (!ok && cfg_autoflush_en) begin ex_fl = 1; return; end
        end
        if (cfg_append_en) begin push_ex(rssi_in); push_ex({ok, lqi_in}); end
    endtask

    task automatic check(input string tag, input bit pass, input int act, input int exp);
        checks++;
        if (!pass) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] lm, input logic [7:0] pl, input logic [1:0] am,
                           input bit crc, input bit app, input bit af);
        cfg_len_mode = lm; cfg_pkt_len = pl; cfg_addr_mode = am;
        cfg_crc_en = crc; cfg_append_en = app; cfg_autoflush_en = af;
    endtask

    task automatic add(input logic [7:0] b);
        pb[pn] = b; pn++;
    endtask

    task automatic add_crc(input bit good);
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < pn; k++) c = b_crc(c, pb[k]);
        if (!good) c = c ^ 16'h0100;
        add(c[15:8]); add(c[7:0]);
    endtask

    task automatic drive();
        @(negedge clk); sync_found = 1'b1;
        @(negedge clk); sync_found = 1'b0;
        for (int k = 0; k < pn; k++) begin
            rx_valid = 1'b1; rx_byte = pb[k];
            @(negedge clk); rx_valid = 1'b0; rx_byte = $urandom;
            @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    // tag names the requirement whose data path is under test
    task automatic run(input string tag, input string rtag);
        bit same;
        model();
        cn = 0; cfl = 0; crs = 0;
        drive();
        check({tag, " write count"}, cn == en, cn, en);
        same = (cn == en);
        for (int k = 0; k < en && same; k++) if (cap[k] !== ex[k]) begin
            same = 1'b0;
            $display("FAIL %s: byte %0d actual=%0h expected=%0h", tag, k, cap[k], ex[k]);
        end
        checks++;
        if (!same) errors++;
        check("R8 flush count", cfl == ex_fl, cfl, ex_fl);
        check({rtag, " restart count"}, crs == ex_rs, crs, ex_rs);
        pn = 0;
    endtask

    initial begin
        #(5ns * 190000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D0C5EED));
        pn = 0;
        repeat (4) @(negedge clk);
        // R11: outputs low in reset
        check("R11 reset outputs", !fifo_we && !fifo_flush && !rx_restart,
              {fifo_we, fifo_flush, rx_restart}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1: fixed length, trailing bytes ignored
        set_cfg(2'd0, 8'd5, 2'd0, 0, 0, 0);
        for (int k = 0; k < 7; k++) add(8'h10 + 8'(k));
        run("R1", "R3");
        // R2 R6 R7: variable, matching address, good CRC, status
        set_cfg(2'd1, 8'd10, 2'd1, 1, 1, 0);
        add(8'd4); add(8'h5A); add(8'h01); add(8'h02); add(8'h03); add_crc(1);
        run("R2 R6 R7", "R5");
        // R3: length over maximum
        set_cfg(2'd1, 8'd6, 2'd0, 1, 1, 0);
        add(8'd9); add(8'h33); add(8'h44);
        run("R3", "R3");
        // R4 R5: address rules
        set_cfg(2'd0, 8'd3, 2'd1, 0, 0, 0); add(8'h00); add(8'h01); add(8'h02);
        run("R5 mode1 0x00", "R5");
        set_cfg(2'd0, 8'd3, 2'd2, 0, 0, 0); add(8'h00); add(8'h01); add(8'h02);
        run("R4 mode2 0x00", "R4");
        set_cfg(2'd0, 8'd3, 2'd2, 0, 0, 0); add(8'hFF); add(8'h01); add(8'h02);
        run("R5 mode2 0xFF", "R5");
        set_cfg(2'd0, 8'd3, 2'd3, 0, 0, 0); add(8'hFF); add(8'h01); add(8'h02);
        run("R4 mode3 0xFF", "R4");
        set_cfg(2'd0, 8'd3, 2'd0, 0, 0, 0); add(8'h77); add(8'h01); add(8'h02);
        run("R4 mode0", "R4");
        // R6 R7: bad CRC without flush
        set_cfg(2'd1, 8'd8, 2'd0, 1, 1, 0);
        add(8'd2); add(8'hA1); add(8'hA2); add_crc(0);
        run("R6 R7 bad crc", "R3");
        // R8: bad CRC with flush
        set_cfg(2'd1, 8'd8, 2'd0, 1, 1, 1);
        add(8'd2); add(8'hA1); add(8'hA2); add_crc(0);
        run("R8", "R3");
        // R7: CRC disabled gives ok bit set
        set_cfg(2'd0, 8'd2, 2'd0, 0, 1, 1);
        add(8'h61); add(8'h62);
        run("R7 crc off", "R3");
        // R2: zero length goes to CRC
        set_cfg(2'd1, 8'd8, 2'd0, 1, 1, 1);
        add(8'd0); add_crc(1);
        run("R2 zero length", "R3");
        // R9: unbounded
        set_cfg(2'd2, 8'd1, 2'd1, 1, 1, 1);
        add(8'h5A); add(8'hB0); add(8'hB1);
        run("R9 match", "R5");
        set_cfg(2'd2, 8'd1, 2'd1, 1, 1, 1);
        add(8'h5B); add(8'hB0);
        run("R9 mismatch", "R5");
        set_cfg(2'd3, 8'd1, 2'd0, 0, 0, 0);
        add(8'h01); add(8'h02);
        run("R9 no filter", "R9");
        // R10: partial packet abandoned by a new start
        set_cfg(2'd0, 8'd6, 2'd0, 1, 1, 0);
        add(8'h21); add(8'h22);
        run("R10 partial", "R10");
        add(8'h31); add(8'h32); add(8'h33); add(8'h34); add(8'h35); add(8'h36); add_crc(1);
        run("R10 after restart", "R10");

        // random mix
        for (int t = 0; t < 250; t++) begin
            logic [1:0] lm;
            int nb;
            lm = 2'($urandom_range(0, 2));
            set_cfg(lm, 8'($urandom_range(0, 10)), 2'($urandom_range(0, 3)),
                    1'($urandom), 1'($urandom), 1'($urandom));
            rssi_in = 8'($urandom); lqi_in = 7'($urandom);
            if (lm == 2'd1) add(8'($urandom_range(0, 12)));
            case ($urandom_range(0, 3))
                0: add(cfg_node_addr);
                1: add(8'h00);
                2: add(8'hFF);
                default: add(8'($urandom));
            endcase
            nb = $urandom_range(0, 11);
            for (int k = 0; k < nb; k++) add(8'($urandom));
            if (lm != 2'd2) begin
                if (lm == 2'd1 && pb[0] <= cfg_pkt_len) pn = int'(pb[0]) + 1;
                if (lm == 2'd0) begin
                    while (pn < int'(cfg_pkt_len)) add(8'($urandom));
                    pn = int'(cfg_pkt_len);
                end
                add_crc($urandom_range(0, 3) != 0);
                if ($urandom_range(0, 1) == 1) add(8'($urandom));
            end
            run(lm == 2'd0 ? "R1 random" : (lm == 2'd1 ? "R2 random" : "R9 random"),
                "R3 or R5");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule